// File: doc/BRIEF.md
# SHA-256 Message Padding Buffer

This block collects a message for SHA-256 hashing and turns it into a correctly padded message in place. Bytes arrive one per clock, qualified by a valid strobe, and the message closes with an end strobe. Each byte goes into an internal byte-wide store that has one write port and one read port. The store is split into four byte lanes. A running pointer counts the message length.

Once the message has closed, the block writes the rest of the padding on its own. It writes a 0x80 marker byte, then zero bytes, then the bit length of the message as a 64-bit big-endian integer. The padded length is always the smallest whole number of 64-byte blocks that fits all of this. After the last padding write, the block raises a ready flag and reports the block count.

A hashing core then reads the padded message as 32-bit big-endian words by word address. Each read request is registered before the store is addressed, so data comes back two cycles after the request.

Top module: `sha_pad_buffer`

## Requirements
- R1: Message bytes are stored in arrival order, one for each cycle in which `byte_valid_i` is high. Cycles with `byte_valid_i` low store nothing and leave no gap.
- R2: A byte that is presented with `byte_valid_i` in the same cycle as `msg_end_i` is the last byte of the message.
- R3: The byte at offset L, where L is the message length in bytes, is 0x80.
- R4: The last 8 bytes of the padded message hold L*8 as a 64-bit big-endian integer, most significant byte first. Every byte between the marker and the length field is 0x00.
- R5: The padded length is 64*N bytes, with N = floor((L+8)/64)+1. When L mod 64 is 56 or more, the padding spills into one extra block.
- R6: `block_cnt_o` equals N while `ready_o` is high, and 0 before that.
- R7: `ready_o` rises only after the last length byte has been written. It then stays high until reset.
- R8: When `rd_req_i` is high in cycle t and ready is high, `rd_valid_o` is high in cycle t+2. In that cycle `rd_data_o` holds bytes 4a..4a+3 of the padded message, with byte 4a in bits [31:24].
- R9: A read request made while `ready_o` is low is dropped, and `rd_valid_o` stays low.
- R10: Bytes and end strobes that arrive after the end of the message do not change the stored message.
- R11: After reset, `ready_o`, `rd_valid_o` and `block_cnt_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_i | input | 8 | Message byte |
| byte_valid_i | input | 1 | `byte_i` carries a message byte this cycle |
| msg_end_i | input | 1 | Message ends this cycle |
| ready_o | output | 1 | Padded message is complete and readable |
| block_cnt_o | output | 8 | Number of 512-bit blocks |
| rd_req_i | input | 1 | Word read request |
| rd_addr_i | input | 8 | Word address |
| rd_data_o | output | 32 | Read word, big-endian |
| rd_valid_o | output | 1 | `rd_data_o` is valid |

## Verification
The last message byte and the end strobe can arrive in the same cycle. The bench provokes this by raising `msg_end_i` together with the final byte for every odd message length. For even lengths it raises the strobe alone one cycle later. Both ways are judged the same way: the whole padded image is read back, and the marker must sit at exactly offset L with the length field equal to L*8. A second overlap is a late byte or end strobe arriving during the padding writes. The bench drives such junk right after the end of every message and expects the image to be unchanged.

// File: rtl/sha_pad_pkg.sv
package sha_pad_pkg;
  localparam int BLOCK_BYTES = 64;
  localparam int LEN_BYTES   = 8;
  localparam int LEN_OFFSET  = BLOCK_BYTES - LEN_BYTES;

  typedef enum logic [2:0] {
    ST_LOAD,
    ST_MARK,
    ST_ZERO,
    ST_LEN,
    ST_DONE
  } pad_state_e;
endpackage

// File: rtl/sha_pad_bank.sv
module sha_pad_bank #(
  parameter int ROWS = 256,
  localparam int AW  = $clog2(ROWS)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [ROWS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/sha_pad_ctrl.sv
module sha_pad_ctrl
  import sha_pad_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int CNT_W = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       byte_i,
  input  logic             byte_valid_i,
  input  logic             msg_end_i,
  output logic             wr_en_o,
  output logic [AW-1:0]    wr_addr_o,
  output logic [7:0]       wr_data_o,
  output logic             ready_o,
  output logic [CNT_W-1:0] block_cnt_o
);
  localparam int BLK_SH = $clog2(BLOCK_BYTES);

  pad_state_e state_q, state_d;
  logic [PW-1:0] wptr_q, wptr_d;
  logic [PW-1:0] len_q, len_d;
  logic [63:0]   bit_len;
  logic [2:0]    len_idx;

  assign bit_len = 64'(len_q) << 3;
  assign len_idx = wptr_q[2:0];

  always_comb begin
    state_d   = state_q;
    wptr_d    = wptr_q;
    len_d     = len_q;
    wr_en_o   = 1'b0;
    wr_data_o = 8'h00;
    unique case (state_q)
      ST_LOAD: begin
        if (byte_valid_i) begin
          wr_en_o   = 1'b1;
          wr_data_o = byte_i;
          wptr_d    = wptr_q + 1'b1;
        end
        if (msg_end_i) begin
          len_d   = wptr_d;
          state_d = ST_MARK;
        end
      end
      ST_MARK: begin
        wr_en_o   = 1'b1;
        wr_data_o = 8'h80;
        wptr_d    = wptr_q + 1'b1;
        state_d   = ST_ZERO;
      end
      ST_ZERO: begin
        if (wptr_q[BLK_SH-1:0] == BLK_SH'(LEN_OFFSET)) begin
          state_d = ST_LEN;
        end else begin
          wr_en_o = 1'b1;
          wptr_d  = wptr_q + 1'b1;
        end
      end
      ST_LEN: begin
        wr_en_o   = 1'b1;
        wr_data_o = 8'(bit_len >> {3'd7 - len_idx, 3'b000});
        wptr_d    = wptr_q + 1'b1;
        if (len_idx == 3'd7) state_d = ST_DONE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_LOAD;
      wptr_q  <= '0;
      len_q   <= '0;
    end else begin
      state_q <= state_d;
      wptr_q  <= wptr_d;
      len_q   <= len_d;
    end
  end

  assign wr_addr_o   = wptr_q[AW-1:0];
  assign ready_o     = (state_q == ST_DONE);
  assign block_cnt_o = ready_o ? CNT_W'(wptr_q >> BLK_SH) : '0;

  AST_READY_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o); // R7
  AST_NO_WRITE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !wr_en_o); // R10
  AST_BLOCK_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> (wptr_q[BLK_SH-1:0] == '0)); // R5
  AST_MARK_AFTER_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOAD && msg_end_i) |=> (wr_en_o && wr_data_o == 8'h80)); // R3
endmodule

// File: rtl/sha_pad_rdport.sv
module sha_pad_rdport #(
  parameter int WAW = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ready_i,
  input  logic           rd_req_i,
  input  logic [WAW-1:0] rd_addr_i,
  output logic           re_o,
  output logic [WAW-1:0] raddr_o,
  output logic           rd_valid_o
);
  logic req_q;
  logic [WAW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q      <= 1'b0;
      addr_q     <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      req_q      <= rd_req_i & ready_i;
      if (rd_req_i) addr_q <= rd_addr_i;
      rd_valid_o <= req_q;
    end
  end

  assign re_o    = req_q;
  assign raddr_o = addr_q;

  AST_RD_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && ready_i) |=> ##1 rd_valid_o); // R8
  AST_NO_READ_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |-> $past(ready_i)); // R9
endmodule

// File: rtl/sha_pad_buffer.sv
module sha_pad_buffer #(
  parameter int DEPTH = 1024,
  parameter int CNT_W = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int WAW  = AW - 2,
  localparam int ROWS = DEPTH / 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       byte_i,
  input  logic             byte_valid_i,
  input  logic             msg_end_i,
  output logic             ready_o,
  output logic [CNT_W-1:0] block_cnt_o,
  input  logic             rd_req_i,
  input  logic [WAW-1:0]   rd_addr_i,
  output logic [31:0]      rd_data_o,
  output logic             rd_valid_o
);
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic          re;
  logic [WAW-1:0] raddr;

  sha_pad_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk_i, .rst_ni, .byte_i, .byte_valid_i, .msg_end_i,
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .ready_o, .block_cnt_o
  );

  sha_pad_rdport #(.WAW(WAW)) u_rdport (
    .clk_i, .rst_ni, .ready_i(ready_o), .rd_req_i, .rd_addr_i,
    .re_o(re), .raddr_o(raddr), .rd_valid_o
  );

  // lane g holds byte offsets 4k+g; lane 0 is the word's MSB
  for (genvar g = 0; g < 4; g++) begin : g_lane
    logic [7:0] lane_q;
    sha_pad_bank #(.ROWS(ROWS)) u_bank (
      .clk_i,
      .we_i   (wr_en && wr_addr[1:0] == 2'(g)),
      .waddr_i(wr_addr[AW-1:2]),
      .wdata_i(wr_data),
      .re_i   (re),
      .raddr_i(raddr),
      .rdata_o(lane_q)
    );
    assign rd_data_o[31-8*g -: 8] = lane_q;
  end
endmodule

// File: tb/sha_pad_buffer_tb.sv
`timescale 1ns/1ps
module sha_pad_buffer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] byte_in = '0;
  logic byte_valid = 1'b0, msg_end = 1'b0, rd_req = 1'b0;
  logic [7:0] rd_addr = '0;
  logic ready, rd_valid;
  logic [7:0] block_cnt;
  logic [31:0] rd_data;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sha_pad_buffer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .byte_i(byte_in), .byte_valid_i(byte_valid),
    .msg_end_i(msg_end), .ready_o(ready), .block_cnt_o(block_cnt),
    .rd_req_i(rd_req), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .rd_valid_o(rd_valid)
  );

  function automatic logic [7:0] msg_byte(int i, int len);
    return 8'((i * 37 + len * 11 + 5) & 255);
  endfunction

  function automatic int nblk(int len);
    return (len + 8) / 64 + 1;
  endfunction

  function automatic logic [7:0] exp_byte(int i, int len);
    int total = nblk(len) * 64;
    logic [63:0] bl = 64'(len) * 8;
    if (i < len) return msg_byte(i, len);
    if (i == len) return 8'h80;
    if (i >= total - 8) return 8'(bl >> (8 * (total - 1 - i)));
    return 8'h00;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic read_word(int a, output logic v, output logic [31:0] d);
    @(negedge clk); rd_req = 1'b1; rd_addr = 8'(a);
    @(negedge clk); rd_req = 1'b0;
    @(negedge clk); v = rd_valid; d = rd_data;
  endtask

  task automatic run_msg(int len);
    bit same = (len > 0) && (len % 2 == 1);
    logic v; logic [31:0] d;
    int wait_c = 0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(!ready && !rd_valid && block_cnt == 0, "R11", "reset outputs",
          {ready, rd_valid, block_cnt}, 0);
    rst_n = 1'b1;
    read_word(0, v, d);
    check(!v, "R9", "read before ready", v, 0);
    for (int i = 0; i < len; i++) begin
      if (i % 7 == 3) begin
        @(negedge clk); byte_valid = 1'b0; byte_in = 8'hA5; msg_end = 1'b0;
      end
      @(negedge clk);
      byte_valid = 1'b1; byte_in = msg_byte(i, len);
      msg_end = same && (i == len - 1);
    end
    if (!same) begin
      @(negedge clk); byte_valid = 1'b0; msg_end = 1'b1;
    end
    // junk after the end: must be ignored (R10)
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); byte_valid = 1'b1; byte_in = 8'hEE; msg_end = (k == 1);
    end
    @(negedge clk); byte_valid = 1'b0; msg_end = 1'b0;
    while (!ready && wait_c < 300) begin
      @(negedge clk); wait_c++;
    end
    check(ready, "R7", "ready reached", ready, 1);
    check(block_cnt == 8'(nblk(len)), "R6 R5", "block count", block_cnt, nblk(len));
    for (int w = 0; w < nblk(len) * 16; w++) begin
      logic [31:0] e;
      e = {exp_byte(4*w, len), exp_byte(4*w+1, len), exp_byte(4*w+2, len), exp_byte(4*w+3, len)};
      read_word(w, v, d);
      check(v, "R8", "read valid", v, 1);
      if (4*w <= len && len < 4*w + 4)
        check(d == e, "R3 R2", "marker word", d, e);
      else if (w >= nblk(len) * 16 - 2)
        check(d == e, "R4", "length word", d, e);
      else
        check(d == e, "R1 R10", "data word", d, e);
    end
    check(ready, "R7", "ready held", ready, 1);
  endtask

  initial begin
    for (int len = 0; len <= 130; len++) run_msg(len);
    run_msg(1015);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int c = 0; c < 190000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule